// File: doc/BRIEF.md
# Big-Endian External Memory Bank Controller

This block sits between one internal bus master and a set of external memory banks. It takes byte, halfword and word requests through a valid/ready handshake. It decodes the request address against eight programmable bank slots and then runs one or more external strobe cycles on the selected bank. Each slot sets its own 16 MB-aligned placement, size, external bus width (8 or 16 bits) and strobe length.

When a request is wider than the bank, the block splits it into a series of narrow external cycles in ascending address order. It places the bytes in big-endian order, so the most significant byte of the request sits at the lowest address. An address that no enabled slot claims ends without any external activity and raises a one-cycle error flag. Bank configuration arrives on static input vectors and is sampled at the moment a request is taken.

Top module: `ext_bank_ctrl`

## Requirements
- R1: A bank slot claims an address when its enable bit is set, address bits [26:24] equal its 3-bit base, and the 24-bit offset is below 16 MB shifted right by its 3-bit size code. Only that bank's active-low chip select (bit n of `ext_cs_n` for slot n) is driven low during its strobe cycles.
- R2: When several enabled slots claim the same address, the slot with the lowest index is used.
- R3: An address that no enabled slot claims produces no chip select, output enable or write enable. `req_ready` and `rsp_err` are both high in the single cycle after the request is taken, and `rsp_rdata` is zero in that cycle.
- R4: Size code 0 is a byte, 1 is a halfword, and 2 or 3 is a word. The number of external cycles is the request's byte count divided by the bank width in bytes, and never less than one.
- R5: External cycles run at ascending byte addresses, and the most significant byte of the request goes to the lowest address. Request and response data are right-aligned in the 32-bit buses.
- R6: On a 16-bit bank, the byte at the even address travels on `ext_dout`/`ext_din` bits [15:8] and the byte at the odd address on bits [7:0]. `ext_lane_n[1]` and `ext_lane_n[0]` are the active-low enables for those two lanes. A byte write to a 16-bit bank enables only its own lane. An 8-bit bank uses bits [7:0] and `ext_lane_n = 2'b10`.
- R7: A strobe cycle lasts v+1 clock cycles, where v is the bank's 3-bit wait field. `ext_oe_n` is low for reads, `ext_we_n` is low for writes, and the two are never low together. `ext_addr` holds steady for the whole strobe.
- R8: There is exactly one clock cycle with no strobe between consecutive external cycles of one request.
- R9: `req_ready` is high for one cycle only: the last strobe cycle of the last external cycle. This gives a latency from acceptance of n*(v+1)+(n-1) cycles for n external cycles. The assembled read data is on `rsp_rdata` in that cycle, and `rsp_rdata` is zero for writes.
- R10: Address bits below the access size (bit 0 for halfwords, bits 1:0 for words) are ignored.
- R11: While `rst_n` is low, all chip selects, `ext_oe_n` and `ext_we_n` are high, and `req_ready` and `rsp_err` are low, whatever the request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 8 | Slot enable bits |
| cfg_base | input | 24 | Slot bases, 3 bits per slot, in 16 MB units |
| cfg_size | input | 24 | Slot size codes, 3 bits per slot (16 MB >> code) |
| cfg_wait | input | 24 | Slot wait fields, 3 bits per slot (v+1 strobe cycles) |
| cfg_wide | input | 8 | Slot width: 1 = 16-bit, 0 = 8-bit |
| req_valid | input | 1 | Request valid, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 27 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| req_ready | output | 1 | Request complete |
| rsp_rdata | output | 32 | Read data, right-aligned |
| rsp_err | output | 1 | Unmapped-address flag |
| ext_addr | output | 24 | Byte offset within the bank |
| ext_cs_n | output | 8 | Active-low bank chip selects |
| ext_oe_n | output | 1 | Active-low output enable |
| ext_we_n | output | 1 | Active-low write enable |
| ext_lane_n | output | 2 | Active-low byte-lane enables |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |

## Verification
The bench uses a configuration in which two slots overlap. A priority inversion therefore shows up as a different chip select and a different cycle count. It reads back words it wrote through 8-bit and 16-bit banks and checks the stored byte order, so a reversed split order or a swapped lane scrambles the bytes. It also issues a byte write to an odd address and checks that the neighbouring byte survives. Cycle-exact latency, strobe-cycle and strobe-episode counts catch an off-by-one in the wait counter and a missing idle gap, since a missing gap merges two episodes. Disabled slots, misaligned word addresses and unmapped writes check that the enable bit is honoured, that low bits are dropped, and that an error produces no strobe.

// File: rtl/embc_pkg.sv
package embc_pkg;

   localparam int REQ_DW = 32;
   localparam int EXT_DW = 16;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STRB = 2'd1,
      ST_GAP  = 2'd2,
      ST_MISS = 2'd3
   } seq_state_e;

   // index of the final external cycle for a request size on a bank width
   function automatic logic [1:0] final_sub(input logic [1:0] sz, input logic wide);
      case (sz)
         2'd0:    final_sub = 2'd0;
         2'd1:    final_sub = wide ? 2'd0 : 2'd1;
         default: final_sub = wide ? 2'd1 : 2'd3;
      endcase
   endfunction

   // address bits cleared for natural alignment
   function automatic logic [1:0] low_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    low_mask = 2'b00;
         2'd1:    low_mask = 2'b01;
         default: low_mask = 2'b11;
      endcase
   endfunction

   // byte j (0 = lowest address) of a right-aligned request word
   function automatic logic [7:0] req_byte(input logic [REQ_DW-1:0] d,
                                           input logic [1:0] sz,
                                           input logic [1:0] j);
      logic [1:0] top;
      logic [1:0] p;
      top = (sz == 2'd0) ? 2'd0 : (sz == 2'd1) ? 2'd1 : 2'd3;
      p   = top - j;
      req_byte = d[{p, 3'b000} +: 8];
   endfunction

endpackage

// File: rtl/embc_bank_decode.sv
module embc_bank_decode #(
   parameter int NBANK  = 8,
   parameter int ADDR_W = 27,
   parameter int EXT_AW = 24,
   parameter int SIZE_W = 3,
   parameter int WAIT_W = 3,
   parameter int IDX_W  = 3
) (
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [NBANK-1:0]                   cfg_en,
   input  logic [NBANK*(ADDR_W-EXT_AW)-1:0]   cfg_base,
   input  logic [NBANK*SIZE_W-1:0]            cfg_size,
   input  logic [NBANK*WAIT_W-1:0]            cfg_wait,
   input  logic [NBANK-1:0]                   cfg_wide,
   output logic                               hit,
   output logic [IDX_W-1:0]                   idx,
   output logic                               wide,
   output logic [WAIT_W-1:0]                  wait_cyc
);
   localparam int BASE_W = ADDR_W - EXT_AW;

   logic [NBANK-1:0] match;

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_slot
         logic [SIZE_W-1:0] code;
         logic [BASE_W-1:0] base;
         assign code = cfg_size[b*SIZE_W +: SIZE_W];
         assign base = cfg_base[b*BASE_W +: BASE_W];
         assign match[b] = cfg_en[b]
                        && (addr[ADDR_W-1:EXT_AW] == base)
                        && ((addr[EXT_AW-1:0] >> (EXT_AW - int'(code))) == '0);
      end
   endgenerate

   // lowest index wins: scan downward so the last hit written is the smallest
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int b = NBANK - 1; b >= 0; b--) begin
         if (match[b]) begin
            hit = 1'b1;
            idx = IDX_W'(b);
         end
      end
   end

   assign wide     = cfg_wide[idx];
   assign wait_cyc = cfg_wait[idx*WAIT_W +: WAIT_W];

endmodule

// File: rtl/embc_lane_steer.sv
module embc_lane_steer
   import embc_pkg::*;
(
   input  logic [REQ_DW-1:0] wdata,
   input  logic [1:0]        size,
   input  logic              wide,
   input  logic [1:0]        sub,
   input  logic              odd,
   input  logic [REQ_DW-1:0] acc,
   input  logic [EXT_DW-1:0] din,
   output logic [EXT_DW-1:0] dout,
   output logic [1:0]        lane_n,
   output logic [REQ_DW-1:0] acc_nx
);
   logic [1:0] j_hi;
   logic [1:0] j_lo;
   logic [7:0] b_single;

   assign j_hi     = {sub[0], 1'b0};
   assign j_lo     = {sub[0], 1'b1};
   assign b_single = req_byte(wdata, size, 2'd0);

   always_comb begin
      if (wide) begin
         if (size == 2'd0) begin
            dout   = {b_single, b_single};
            lane_n = odd ? 2'b10 : 2'b01;
         end else begin
            dout   = {req_byte(wdata, size, j_hi), req_byte(wdata, size, j_lo)};
            lane_n = 2'b00;
         end
      end else begin
         dout   = {8'h00, req_byte(wdata, size, sub)};
         lane_n = 2'b10;
      end
   end

   always_comb begin
      if (wide) begin
         if (size == 2'd0)
            acc_nx = {24'h0, odd ? din[7:0] : din[15:8]};
         else
            acc_nx = {acc[15:0], din};
      end else begin
         acc_nx = {acc[23:0], din[7:0]};
      end
   end

endmodule

// File: rtl/ext_bank_ctrl.sv
module ext_bank_ctrl
   import embc_pkg::*;
#(
   parameter int NBANK  = 8,
   parameter int ADDR_W = 27,
   parameter int EXT_AW = 24,
   parameter int SIZE_W = 3,
   parameter int WAIT_W = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NBANK-1:0]                  cfg_en,
   input  logic [NBANK*(ADDR_W-EXT_AW)-1:0]  cfg_base,
   input  logic [NBANK*SIZE_W-1:0]           cfg_size,
   input  logic [NBANK*WAIT_W-1:0]           cfg_wait,
   input  logic [NBANK-1:0]                  cfg_wide,
   input  logic                              req_valid,
   input  logic                              req_write,
   input  logic [1:0]                        req_size,
   input  logic [ADDR_W-1:0]                 req_addr,
   input  logic [31:0]                       req_wdata,
   output logic                              req_ready,
   output logic [31:0]                       rsp_rdata,
   output logic                              rsp_err,
   output logic [EXT_AW-1:0]                 ext_addr,
   output logic [NBANK-1:0]                  ext_cs_n,
   output logic                              ext_oe_n,
   output logic                              ext_we_n,
   output logic [1:0]                        ext_lane_n,
   output logic [15:0]                       ext_dout,
   input  logic [15:0]                       ext_din
);
   localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

   generate
      if (ADDR_W <= EXT_AW) begin : g_chk_aw
         $error("ext_bank_ctrl: ADDR_W must exceed EXT_AW");
      end
      if ((1 << SIZE_W) > EXT_AW) begin : g_chk_sz
         $error("ext_bank_ctrl: size code range exceeds bank offset width");
      end
      if (NBANK < 1 || NBANK > (1 << (ADDR_W - EXT_AW))) begin : g_chk_nb
         $error("ext_bank_ctrl: NBANK out of range for base field");
      end
      if (WAIT_W < 1) begin : g_chk_w
         $error("ext_bank_ctrl: WAIT_W must be at least 1");
      end
   endgenerate

   seq_state_e           state_q;
   logic                 wr_q;
   logic [1:0]           size_q;
   logic [31:0]          wdata_q;
   logic [EXT_AW-1:0]    addr_q;
   logic [IDX_W-1:0]     idx_q;
   logic                 wide_q;
   logic [WAIT_W-1:0]    wait_q;
   logic [WAIT_W-1:0]    cnt_q;
   logic [1:0]           sub_q;
   logic [1:0]           final_q;
   logic [31:0]          acc_q;

   logic [ADDR_W-1:0]    addr_al;
   logic                 dec_hit;
   logic [IDX_W-1:0]     dec_idx;
   logic                 dec_wide;
   logic [WAIT_W-1:0]    dec_wait;
   logic [15:0]          lane_dout;
   logic [1:0]           lane_sel_n;
   logic [31:0]          acc_nx;
   logic                 strb;
   logic                 seg_end;
   logic                 xfer_end;

   assign addr_al = {req_addr[ADDR_W-1:2], req_addr[1:0] & ~low_mask(req_size)};

   embc_bank_decode #(
      .NBANK(NBANK), .ADDR_W(ADDR_W), .EXT_AW(EXT_AW),
      .SIZE_W(SIZE_W), .WAIT_W(WAIT_W), .IDX_W(IDX_W)
   ) u_decode (
      .addr     (addr_al),
      .cfg_en   (cfg_en),
      .cfg_base (cfg_base),
      .cfg_size (cfg_size),
      .cfg_wait (cfg_wait),
      .cfg_wide (cfg_wide),
      .hit      (dec_hit),
      .idx      (dec_idx),
      .wide     (dec_wide),
      .wait_cyc (dec_wait)
   );

   embc_lane_steer u_lanes (
      .wdata  (wdata_q),
      .size   (size_q),
      .wide   (wide_q),
      .sub    (sub_q),
      .odd    (addr_q[0]),
      .acc    (acc_q),
      .din    (ext_din),
      .dout   (lane_dout),
      .lane_n (lane_sel_n),
      .acc_nx (acc_nx)
   );

   assign strb     = (state_q == ST_STRB);
   assign seg_end  = strb && (cnt_q == '0);
   assign xfer_end = seg_end && (sub_q == final_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         size_q  <= 2'd0;
         wdata_q <= '0;
         addr_q  <= '0;
         idx_q   <= '0;
         wide_q  <= 1'b0;
         wait_q  <= '0;
         cnt_q   <= '0;
         sub_q   <= 2'd0;
         final_q <= 2'd0;
         acc_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  wr_q    <= req_write;
                  size_q  <= req_size;
                  wdata_q <= req_wdata;
                  addr_q  <= addr_al[EXT_AW-1:0];
                  acc_q   <= '0;
                  sub_q   <= 2'd0;
                  if (dec_hit) begin
                     idx_q   <= dec_idx;
                     wide_q  <= dec_wide;
                     wait_q  <= dec_wait;
                     cnt_q   <= dec_wait;
                     final_q <= final_sub(req_size, dec_wide);
                     state_q <= ST_STRB;
                  end else begin
                     state_q <= ST_MISS;
                  end
               end
            end
            ST_STRB: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else begin
                  acc_q <= acc_nx;
                  if (sub_q == final_q) begin
                     state_q <= ST_IDLE;
                  end else begin
                     sub_q   <= sub_q + 2'd1;
                     addr_q  <= addr_q + EXT_AW'(wide_q ? 2 : 1);
                     state_q <= ST_GAP;
                  end
               end
            end
            ST_GAP: begin
               cnt_q   <= wait_q;
               state_q <= ST_STRB;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ext_cs_n   = strb ? ~(NBANK'(1) << idx_q) : '1;
   assign ext_oe_n   = ~(strb && !wr_q);
   assign ext_we_n   = ~(strb && wr_q);
   assign ext_lane_n = strb ? lane_sel_n : 2'b11;
   assign ext_dout   = lane_dout;
   assign ext_addr   = addr_q;
   assign req_ready  = xfer_end || (state_q == ST_MISS);
   assign rsp_err    = (state_q == ST_MISS);
   assign rsp_rdata  = (xfer_end && !wr_q) ? acc_nx : '0;

   // R1: never more than one bank selected
   a_r1_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ext_cs_n));

   // R7: read and write strobes are exclusive
   a_r7_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ext_oe_n && !ext_we_n));

   // R7: address steady across a held strobe
   a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_oe_n || !ext_we_n) && !(ext_oe_n && ext_we_n) && $past(strb) && strb
      |-> $stable(ext_addr));

   // R3: an error completion carries no strobe and completes the request
   a_r3_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (&ext_cs_n && ext_oe_n && ext_we_n && req_ready && rsp_rdata == '0));

   // R8: a non-final segment is followed by one idle cycle, then a new strobe
   a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_end && !xfer_end) |=> (&ext_cs_n ##1 !(&ext_cs_n)));

   // R9: ready is a single-cycle pulse
   a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

endmodule

// File: tb/tb_ext_bank_ctrl.sv
`timescale 1ns/1ps
module tb_ext_bank_ctrl;

   localparam int NV = 17;
   localparam int VW = 115;

   // fields: wr | size | addr | wdata | exp_rdata | exp_err | lat | subs | cs
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b1, 2'd2, 27'h0000010, 32'h11223344, 32'h00000000, 1'b0, 8'd5,  4'd2, 8'h01},
      {1'b0, 2'd2, 27'h0000010, 32'h00000000, 32'h11223344, 1'b0, 8'd5,  4'd2, 8'h01},
      {1'b0, 2'd1, 27'h0000012, 32'h00000000, 32'h00003344, 1'b0, 8'd2,  4'd1, 8'h01},
      {1'b0, 2'd0, 27'h0000011, 32'h00000000, 32'h00000022, 1'b0, 8'd2,  4'd1, 8'h01},
      {1'b1, 2'd2, 27'h1000020, 32'hA1B2C3D4, 32'h00000000, 1'b0, 8'd7,  4'd4, 8'h02},
      {1'b0, 2'd2, 27'h1000020, 32'h00000000, 32'hA1B2C3D4, 1'b0, 8'd7,  4'd4, 8'h02},
      {1'b0, 2'd1, 27'h1000022, 32'h00000000, 32'h0000C3D4, 1'b0, 8'd3,  4'd2, 8'h02},
      {1'b1, 2'd0, 27'h0000013, 32'h000000EE, 32'h00000000, 1'b0, 8'd2,  4'd1, 8'h01},
      {1'b0, 2'd2, 27'h0000010, 32'h00000000, 32'h112233EE, 1'b0, 8'd5,  4'd2, 8'h01},
      {1'b1, 2'd1, 27'h2000040, 32'h0000BEEF, 32'h00000000, 1'b0, 8'd3,  4'd1, 8'h04},
      {1'b0, 2'd1, 27'h2000040, 32'h00000000, 32'h0000BEEF, 1'b0, 8'd3,  4'd1, 8'h04},
      {1'b1, 2'd2, 27'h2100008, 32'h01020304, 32'h00000000, 1'b0, 8'd11, 4'd4, 8'h08},
      {1'b0, 2'd2, 27'h2100008, 32'h00000000, 32'h01020304, 1'b0, 8'd11, 4'd4, 8'h08},
      {1'b0, 2'd2, 27'h4000000, 32'h00000000, 32'h00000000, 1'b1, 8'd1,  4'd0, 8'h00},
      {1'b0, 2'd2, 27'h7000000, 32'h00000000, 32'h00000000, 1'b1, 8'd1,  4'd0, 8'h00},
      {1'b0, 2'd2, 27'h0000012, 32'h00000000, 32'h112233EE, 1'b0, 8'd5,  4'd2, 8'h01},
      {1'b1, 2'd2, 27'h5000000, 32'hFFFFFFFF, 32'h00000000, 1'b1, 8'd1,  4'd0, 8'h00}
   };

   localparam logic [7:0] BANK_WIDE = 8'b0000_0101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_en   = 8'h0F;
   logic [23:0] cfg_base = {3'd7, 3'd6, 3'd5, 3'd4, 3'd2, 3'd2, 3'd1, 3'd0};
   logic [23:0] cfg_size = {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd4, 3'd0, 3'd0};
   logic [23:0] cfg_wait = {3'd0, 3'd0, 3'd0, 3'd0, 3'd1, 3'd2, 3'd0, 3'd1};
   logic [7:0]  cfg_wide = BANK_WIDE;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [26:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready;
   logic [31:0] rsp_rdata;
   logic        rsp_err;
   logic [23:0] ext_addr;
   logic [7:0]  ext_cs_n;
   logic        ext_oe_n;
   logic        ext_we_n;
   logic [1:0]  ext_lane_n;
   logic [15:0] ext_dout;
   logic [15:0] ext_din;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   ext_bank_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_size(cfg_size),
      .cfg_wait(cfg_wait), .cfg_wide(cfg_wide),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n),
      .ext_we_n(ext_we_n), .ext_lane_n(ext_lane_n),
      .ext_dout(ext_dout), .ext_din(ext_din)
   );

   // external memory model: 256 bytes per bank, indexed by low offset bits
   logic [7:0] mem [8][256];

   initial begin
      for (int b = 0; b < 8; b++)
         for (int a = 0; a < 256; a++)
            mem[b][a] = 8'h00;
   end

   always_comb begin
      ext_din = 16'h0000;
      for (int b = 0; b < 8; b++) begin
         if (!ext_cs_n[b] && !ext_oe_n) begin
            if (BANK_WIDE[b])
               ext_din = {mem[b][{ext_addr[7:1], 1'b0}], mem[b][{ext_addr[7:1], 1'b1}]};
            else
               ext_din = {8'h00, mem[b][ext_addr[7:0]]};
         end
      end
   end

   always @(posedge clk) begin
      for (int b = 0; b < 8; b++) begin
         if (!ext_cs_n[b] && !ext_we_n) begin
            if (BANK_WIDE[b]) begin
               if (!ext_lane_n[1]) mem[b][{ext_addr[7:1], 1'b0}] <= ext_dout[15:8];
               if (!ext_lane_n[0]) mem[b][{ext_addr[7:1], 1'b1}] <= ext_dout[7:0];
            end else if (!ext_lane_n[0]) begin
               mem[b][ext_addr[7:0]] <= ext_dout[7:0];
            end
         end
      end
   end

   // strobe monitor, sampled away from the active edge
   int       episodes;
   int       strb_cycles;
   int       err_cycles;
   logic [7:0] cs_seen;
   logic     prev_strb;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!(&ext_cs_n) && !prev_strb) episodes++;
         if (!(&ext_cs_n)) strb_cycles++;
         if (rsp_err) err_cycles++;
         cs_seen  |= ~ext_cs_n;
         prev_strb = !(&ext_cs_n);
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_req(input logic wr, input logic [1:0] sz, input logic [26:0] addr,
                          input logic [31:0] wd, output int lat, output logic [31:0] rd,
                          output logic er);
      @(posedge clk);
      #1;
      req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
      episodes = 0; strb_cycles = 0; err_cycles = 0; cs_seen = 8'h00; prev_strb = 1'b0;
      req_valid = 1'b1;
      lat = 0; rd = '0; er = 1'b0;
      for (int k = 0; k < 40; k++) begin
         @(posedge clk);
         #1;
         lat++;
         if (req_ready) begin
            rd = rsp_rdata;
            er = rsp_err;
            break;
         end
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int       lat;
      logic [31:0] rd;
      logic     er;

      // R11: reset holds outputs quiet even with a valid request pending
      req_valid = 1'b1; req_addr = 27'h0000010; req_size = 2'd2;
      repeat (3) @(posedge clk);
      #1;
      check(ext_cs_n == 8'hFF, "R11 cs during reset", {24'h0, ext_cs_n}, 32'h000000FF);
      check(ext_oe_n && ext_we_n, "R11 oe/we during reset", {30'h0, ext_oe_n, ext_we_n}, 32'h3);
      check(!req_ready && !rsp_err, "R11 ready/err during reset", {30'h0, req_ready, rsp_err}, 32'h0);
      req_valid = 1'b0;
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // table walk: R1 R2 R3 R4 R5 R7 R8 R9 R10
      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         int           exp_strb;
         v = VEC[i];
         run_req(v[114], v[113:112], v[111:85], v[84:53], lat, rd, er);
         exp_strb = (v[11:8] == 0) ? 0 : int'(v[19:12]) - (int'(v[11:8]) - 1);
         check(lat == int'(v[19:12]), $sformatf("R9 latency vec%0d", i), lat, {24'h0, v[19:12]});
         check(rd == v[52:21], $sformatf("R5 rdata vec%0d", i), rd, v[52:21]);
         check(er == v[20], $sformatf("R3 err vec%0d", i), {31'h0, er}, {31'h0, v[20]});
         check(episodes == int'(v[11:8]), $sformatf("R4 R8 episodes vec%0d", i), episodes, {28'h0, v[11:8]});
         check(cs_seen == v[7:0], $sformatf("R1 R2 cs vec%0d", i), {24'h0, cs_seen}, {24'h0, v[7:0]});
         check(strb_cycles == exp_strb, $sformatf("R7 strobe cycles vec%0d", i), strb_cycles, exp_strb);
         check(err_cycles == (v[20] ? 1 : 0), $sformatf("R3 err pulse vec%0d", i), err_cycles, {31'h0, v[20]});
      end

      // R5: stored byte order on an 8-bit bank
      check(mem[1][8'h20] == 8'hA1, "R5 byte0 narrow bank", {24'h0, mem[1][8'h20]}, 32'hA1);
      check(mem[1][8'h21] == 8'hB2, "R5 byte1 narrow bank", {24'h0, mem[1][8'h21]}, 32'hB2);
      check(mem[1][8'h23] == 8'hD4, "R5 byte3 narrow bank", {24'h0, mem[1][8'h23]}, 32'hD4);
      // R6: odd-address byte write to a 16-bit bank touches only the low lane
      check(mem[0][8'h13] == 8'hEE, "R6 odd byte lane", {24'h0, mem[0][8'h13]}, 32'hEE);
      check(mem[0][8'h12] == 8'h33, "R6 neighbour lane kept", {24'h0, mem[0][8'h12]}, 32'h33);
      check(mem[0][8'h10] == 8'h11, "R5 high byte at low address", {24'h0, mem[0][8'h10]}, 32'h11);
      // R2: priority slot 2 received the halfword, slot 3 region untouched at that offset
      check(mem[2][8'h40] == 8'hBE, "R2 low slot wins", {24'h0, mem[2][8'h40]}, 32'hBE);
      check(mem[3][8'h40] == 8'h00, "R2 higher slot unused", {24'h0, mem[3][8'h40]}, 32'h00);
      // R10: misaligned halfword write lands on the aligned address
      run_req(1'b1, 2'd1, 27'h0000031, 32'h00005A6B, lat, rd, er);
      check(mem[0][8'h30] == 8'h5A && mem[0][8'h31] == 8'h6B, "R10 halfword alignment",
            {16'h0, mem[0][8'h30], mem[0][8'h31]}, 32'h5A6B);
      // R6: even byte read on a 16-bit bank comes from the upper lane
      run_req(1'b0, 2'd0, 27'h0000030, 32'h0, lat, rd, er);
      check(rd == 32'h0000005A, "R6 even byte read", rd, 32'h5A);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule